// File: doc/BRIEF.md
# Power-Fail-Safe Flash Block Update Sequencer

This block commits a small parameter block (two data words) to page-erasable flash so that a loss of power at any point never leaves the destination holding half-written data. A normal update runs in two phases. In the first phase the sequencer erases a scratch page, writes both data words into it, and then writes a progress marker. In the second phase it erases the two destination pages, programs one word into each, and only then clears the marker. When it leaves reset it reads the marker back. If the marker shows that an update was interrupted, the sequencer copies the scratch contents to the destination before it accepts any new work.

Two lighter and heavier variants share the same engine. A table update erases one page and programs two rows without using the scratch page. An end-of-discharge save runs the full two-phase update twice, once for each of two destination page pairs. Every flash operation has its own cycle budget. An operation whose done pulse does not arrive within that budget aborts the sequence with an error.

Requests arrive on a valid/ready port. `req_ready` is high only while the sequencer is idle, and a request is taken on the cycle where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and its payload until that cycle. `busy` is high from the cycle after acceptance, and during any restore, until the last flash operation ends; the host side uses it to stretch its bus. Flash commands use a hold-until-done handshake.

Top module: `fbu_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle. A request accepted while idle makes `busy` high on the next cycle. While `busy` is high, `req_ready` stays low, `req_valid` is ignored, and no extra flash command results.
- R2: Flash commands are encoded on `fl_op` as 0 = read, 1 = page erase, 2 = row program. Page 0 is the scratch page and page 5 is the table page. Pass p of an update targets destination pages 1+2p (word 0) and 2+2p (word 1), always at row 0. A request with `req_kind` 0 or 3 is a single update with pass 0.
- R3: A single update issues this command sequence, each command only after the previous one is done:
  1. erase page 0;
  2. program page 0 row 0 with `req_d0`;
  3. program page 0 row 1 with `req_d1`;
  4. program page 0 row 2 with the marker;
  5. erase the two destination pages;
  6. program the two destination rows;
  7. program page 0 row 2 with all zeros.

  The marker word is `{TAG, p}`, with TAG in the upper W-1 bits and the pass bit in bit 0. It is written only after both data rows are written, and it is cleared only after both destination rows are programmed.
- R4: A table update (`req_kind` 1) issues erase of page 5, then programs page 5 row 0 with `req_d0` and page 5 row 1 with `req_d1`. It never touches page 0.
- R5: An end-of-discharge save (`req_kind` 2) runs the R3 sequence with pass 0 and then runs it again with pass 1 without releasing `busy`.
- R6: On leaving reset the sequencer is busy and reads page 0 row 2. If bits W-1:1 equal TAG, it reads rows 0 and 1 of page 0. It then erases and programs the destination pair selected by bit 0 of the marker, using the two words it read, and clears the marker.
- R7: If the marker read at reset does not carry TAG, the restore ends after that single read and the sequencer goes idle.
- R8: If `fl_done` has not arrived within READ_LIMIT, ERASE_LIMIT or PROG_LIMIT cycles of a read, erase or program command:
  - `err` goes high;
  - `fl_valid` and `busy` drop;
  - the sequencer returns to idle.

  `err` stays high until the next accepted request clears it.
- R9: Once `fl_valid` is raised, `fl_op`, `fl_page`, `fl_row` and `fl_wdata` stay unchanged until `fl_done` is seen or the budget expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (models power return) |
| req_valid | input | 1 | Update request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_kind | input | 2 | 0/3 single update, 1 table update, 2 end-of-discharge save |
| req_d0 | input | W | First data word of the block |
| req_d1 | input | W | Second data word of the block |
| busy | output | 1 | Sequence or restore in progress (bus stretch) |
| err | output | 1 | Last sequence aborted on a budget overrun |
| fl_valid | output | 1 | Flash command presented |
| fl_op | output | 2 | Flash operation code |
| fl_page | output | 3 | Flash page index |
| fl_row | output | 2 | Row within the page |
| fl_wdata | output | W | Program data |
| fl_rdata | input | W | Read data, valid with `fl_done` |
| fl_done | input | 1 | Flash operation complete |

## Verification
The bench cuts power with `rst_n` after the marker has been written and while a destination erase is still running. It expects a restore that replays the buffered words. A design that trusted the marker too early, or that skipped the replay, would leave the destination erased or holding stale data. A reset over an already-cleared marker must produce exactly one read, so a design that always replays would show up as unexpected commands. A flash that never answers an erase checks that the budget abort drops `busy`; a design without it would hang the bus. Requests offered while busy must not start a second sequence. The end-of-discharge save must move to the second page pair with the pass bit set in its marker.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_ERASE = 2'd1;
  localparam logic [1:0] OP_PROG  = 2'd2;

  localparam logic [2:0] PG_SCRATCH = 3'd0;
  localparam logic [2:0] PG_TABLE   = 3'd5;

  typedef enum logic [1:0] {M_BLOCK, M_TABLE, M_EOD, M_RESTORE} mode_e;
  typedef enum logic [1:0] {WS_D0, WS_D1, WS_MARK, WS_ZERO} wsel_e;

  typedef struct packed {
    logic [1:0] op;
    logic [2:0] page;
    logic [1:0] row;
    wsel_e      wsel;
    logic       last;
  } step_t;
endpackage

// File: rtl/fbu_step_decode.sv
module fbu_step_decode
  import fbu_pkg::*;
(
  input  mode_e      mode,
  input  logic       pass,
  input  logic [3:0] step,
  output step_t      s
);
  logic [2:0] pg_a, pg_b;
  assign pg_a = 3'd1 + {1'b0, pass, 1'b0};
  assign pg_b = 3'd2 + {1'b0, pass, 1'b0};

  always_comb begin
    s = '{op: OP_READ, page: PG_SCRATCH, row: 2'd0, wsel: WS_ZERO, last: 1'b0};
    unique case (mode)
      M_TABLE: begin
        s.page = PG_TABLE;
        case (step)
          4'd0:    s.op = OP_ERASE;
          4'd1:    begin s.op = OP_PROG; s.wsel = WS_D0; end
          default: begin s.op = OP_PROG; s.row = 2'd1; s.wsel = WS_D1; s.last = 1'b1; end
        endcase
      end
      M_RESTORE: begin
        case (step)
          4'd0:    s.row = 2'd2;
          4'd1:    s.row = 2'd0;
          default: begin s.row = 2'd1; s.last = 1'b1; end
        endcase
      end
      default: begin
        case (step)
          4'd0: s.op = OP_ERASE;
          4'd1: begin s.op = OP_PROG; s.wsel = WS_D0; end
          4'd2: begin s.op = OP_PROG; s.row = 2'd1; s.wsel = WS_D1; end
          4'd3: begin s.op = OP_PROG; s.row = 2'd2; s.wsel = WS_MARK; end
          4'd4: begin s.op = OP_ERASE; s.page = pg_a; end
          4'd5: begin s.op = OP_ERASE; s.page = pg_b; end
          4'd6: begin s.op = OP_PROG; s.page = pg_a; s.wsel = WS_D0; end
          4'd7: begin s.op = OP_PROG; s.page = pg_b; s.wsel = WS_D1; end
          default: begin s.op = OP_PROG; s.row = 2'd2; s.wsel = WS_ZERO; s.last = 1'b1; end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/fbu_op_timer.sv
module fbu_op_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run)           cnt <= '0;
    else if (cnt != limit)   cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == limit);

  // R8: the count never passes the budget of the running operation
  assert_budget_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run && $stable(limit) |-> cnt <= limit);
endmodule

// File: rtl/fbu_seq.sv
module fbu_seq
  import fbu_pkg::*;
#(
  parameter int         W           = 16,
  parameter logic [14:0] TAG        = 15'h2D4B,
  parameter int         ERASE_LIMIT = 40,
  parameter int         PROG_LIMIT  = 8,
  parameter int         READ_LIMIT  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [1:0]   req_kind,
  input  logic [W-1:0] req_d0,
  input  logic [W-1:0] req_d1,
  output logic         busy,
  output logic         err,
  output logic         fl_valid,
  output logic [1:0]   fl_op,
  output logic [2:0]   fl_page,
  output logic [1:0]   fl_row,
  output logic [W-1:0] fl_wdata,
  input  logic [W-1:0] fl_rdata,
  input  logic         fl_done
);
  localparam int MAXL = (ERASE_LIMIT > PROG_LIMIT)
                        ? ((ERASE_LIMIT > READ_LIMIT) ? ERASE_LIMIT : READ_LIMIT)
                        : ((PROG_LIMIT > READ_LIMIT) ? PROG_LIMIT : READ_LIMIT);
  localparam int CW = $clog2(MAXL + 1);
  localparam int TW = W - 1;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_GAP} state_e;

  state_e      state;
  mode_e       mode;
  logic        pass;
  logic [3:0]  step;
  logic [W-1:0] d0, d1;
  step_t       cur;
  logic        tmo;
  logic [CW-1:0] limit;
  logic        accept;

  fbu_step_decode u_dec (.mode(mode), .pass(pass), .step(step), .s(cur));

  always_comb begin
    unique case (cur.op)
      OP_ERASE: limit = CW'(ERASE_LIMIT);
      OP_PROG:  limit = CW'(PROG_LIMIT);
      default:  limit = CW'(READ_LIMIT);
    endcase
  end

  fbu_op_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(state == S_CMD), .limit(limit), .expired(tmo));

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign accept    = req_valid && req_ready;
  assign fl_valid  = (state == S_CMD);
  assign fl_op     = cur.op;
  assign fl_page   = cur.page;
  assign fl_row    = cur.row;

  always_comb begin
    unique case (cur.wsel)
      WS_D0:   fl_wdata = d0;
      WS_D1:   fl_wdata = d1;
      WS_MARK: fl_wdata = {TAG[TW-1:0], pass};
      default: fl_wdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_CMD;
      mode  <= M_RESTORE;
      pass  <= 1'b0;
      step  <= '0;
      d0    <= '0;
      d1    <= '0;
      err   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          state <= S_CMD;
          step  <= '0;
          pass  <= 1'b0;
          d0    <= req_d0;
          d1    <= req_d1;
          err   <= 1'b0;
          unique case (req_kind)
            2'd1:    mode <= M_TABLE;
            2'd2:    mode <= M_EOD;
            default: mode <= M_BLOCK;
          endcase
        end
        S_GAP: state <= S_CMD;
        default: begin
          if (fl_done) begin
            state <= S_GAP;
            if (mode == M_RESTORE) begin
              unique case (step)
                4'd0: begin
                  if (fl_rdata[W-1:1] == TAG[TW-1:0]) begin
                    pass <= fl_rdata[0];
                    step <= 4'd1;
                  end else state <= S_IDLE;
                end
                4'd1: begin d0 <= fl_rdata; step <= 4'd2; end
                default: begin d1 <= fl_rdata; mode <= M_BLOCK; step <= 4'd4; end
              endcase
            end else if (cur.last) begin
              if (mode == M_EOD && !pass) begin
                pass <= 1'b1;
                step <= '0;
              end else state <= S_IDLE;
            end else step <= step + 1'b1;
          end else if (tmo) begin
            state <= S_IDLE;
            err   <= 1'b1;
          end
        end
      endcase
    end
  end

  // R1: an accepted request makes the block busy on the next cycle
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !req_ready);

  // R9: a pending flash command is held steady until done or budget expiry
  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && !fl_done && !tmo |=> fl_valid && $stable(fl_op) && $stable(fl_page)
      && $stable(fl_row) && $stable(fl_wdata));

  // R8: a raised error finds the sequencer idle with no command out
  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && !fl_valid);

  // R4: the table update never addresses the scratch page
  assert_table_no_scratch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && mode == M_TABLE |-> fl_page == PG_TABLE);

  // R6: a restore only issues reads
  assert_restore_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && mode == M_RESTORE |-> fl_op == OP_READ && fl_page == PG_SCRATCH);
endmodule

// File: tb/fbu_seq_bench.sv
module fbu_seq_bench;
  localparam int W = 16;
  localparam logic [14:0] TAG = 15'h2D4B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [W-1:0] req_d0 = '0, req_d1 = '0;
  logic busy, err, fl_valid;
  logic [1:0] fl_op;
  logic [2:0] fl_page;
  logic [1:0] fl_row;
  logic [W-1:0] fl_wdata;
  logic [W-1:0] fl_rdata = '0;
  logic fl_done = 1'b0;

  always #4 clk = ~clk;

  fbu_seq u_fbu_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_d0(req_d0), .req_d1(req_d1), .busy(busy), .err(err),
    .fl_valid(fl_valid), .fl_op(fl_op), .fl_page(fl_page), .fl_row(fl_row),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_done(fl_done));

  typedef struct {logic [1:0] op; logic [2:0] page; logic [1:0] row; logic [W-1:0] data;} cmd_t;
  cmd_t exp_q[$];

  int vectors = 0;
  int miscompares = 0;
  logic [W-1:0] mem [0:5][0:3];
  bit hang = 0;
  bit pend = 0;
  int cnt = 0;
  cmd_t cur;

  function automatic logic [W-1:0] mark(input logic p);
    return {TAG, p};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [2:0] pg, input logic [1:0] row,
                      input logic [W-1:0] d);
    cmd_t c;
    c.op = op; c.page = pg; c.row = row; c.data = d;
    exp_q.push_back(c);
  endtask

  // R3 ordering of one pass, starting at a given step
  task automatic exp_block(input logic p, input logic [W-1:0] a, input logic [W-1:0] b,
                           input int from);
    logic [2:0] pa, pb;
    pa = 3'd1 + {1'b0, p, 1'b0};
    pb = 3'd2 + {1'b0, p, 1'b0};
    if (from == 0) begin
      push(2'd1, 3'd0, 2'd0, '0);
      push(2'd2, 3'd0, 2'd0, a);
      push(2'd2, 3'd0, 2'd1, b);
      push(2'd2, 3'd0, 2'd2, mark(p));
    end
    push(2'd1, pa, 2'd0, '0);
    push(2'd1, pb, 2'd0, '0);
    push(2'd2, pa, 2'd0, a);
    push(2'd2, pb, 2'd0, b);
    push(2'd2, 3'd0, 2'd2, '0);
  endtask

  // flash model and scoreboard monitor
  always @(negedge clk) begin
    fl_done = 1'b0;
    if (!rst_n || !fl_valid) pend = 0;
    else if (!pend) begin
      pend = 1;
      cur.op = fl_op; cur.page = fl_page; cur.row = fl_row; cur.data = fl_wdata;
      cnt = (fl_op == 2'd1) ? 12 : (fl_op == 2'd2) ? 3 : 2;
      if (exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R1 unexpected command actual=%0d/%0d/%0d expected=none",
                 fl_op, fl_page, fl_row);
      end else begin
        cmd_t e;
        e = exp_q.pop_front();
        check("R3 command op", {14'd0, fl_op}, {14'd0, e.op});
        check("R2 command page", {13'd0, fl_page}, {13'd0, e.page});
        check("R2 command row", {14'd0, fl_row}, {14'd0, e.row});
        if (e.op == 2'd2) check("R3 program data", fl_wdata, e.data);
      end
    end else if (!(hang && cur.op == 2'd1)) begin
      cnt--;
      if (cnt == 0) begin
        if (cur.op == 2'd1) for (int r = 0; r < 4; r++) mem[cur.page][r] = '1;
        else if (cur.op == 2'd2) mem[cur.page][cur.row] = mem[cur.page][cur.row] & cur.data;
        fl_rdata = mem[cur.page][cur.row];
        fl_done = 1'b1;
        pend = 0;
      end
    end
  end

  task automatic wait_idle;
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] k, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_kind = k; req_d0 = a; req_d1 = b;
    @(negedge clk);
    req_valid = 0;
    check("R1 busy after accept", {15'd0, busy}, 16'd1);
    check("R1 ready low while busy", {15'd0, req_ready}, 16'd0);
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    for (int p = 0; p < 6; p++) for (int r = 0; r < 4; r++) mem[p][r] = '1;
    push(2'd0, 3'd0, 2'd2, '0);               // R7: erased marker -> single read
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R6 busy at reset exit", {15'd0, busy}, 16'd1);
    wait_idle();
    check("R7 idle after blank marker", {15'd0, busy}, 16'd0);
    check("R1 ready when idle", {15'd0, req_ready}, 16'd1);
    check("R8 err clear at reset", {15'd0, err}, 16'd0);

    // R3: single update
    exp_block(1'b0, 16'h1234, 16'hABCD, 0);
    send(2'd0, 16'h1234, 16'hABCD);
    wait_idle();
    check("R3 dest A", mem[1][0], 16'h1234);
    check("R3 dest B", mem[2][0], 16'hABCD);
    check("R3 marker cleared", mem[0][2], 16'h0000);
    check("R3 all commands seen", 16'(exp_q.size()), 16'd0);

    // R4: table update, with refused requests while busy (R1)
    push(2'd1, 3'd5, 2'd0, '0);
    push(2'd2, 3'd5, 2'd0, 16'h0F0F);
    push(2'd2, 3'd5, 2'd1, 16'h3C3C);
    send(2'd1, 16'h0F0F, 16'h3C3C);
    req_valid = 1; req_kind = 2'd2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 refused while busy", {15'd0, req_ready}, 16'd0);
    end
    req_valid = 0;
    wait_idle();
    check("R4 table row0", mem[5][0], 16'h0F0F);
    check("R4 table row1", mem[5][1], 16'h3C3C);
    check("R4 scratch untouched", mem[0][2], 16'h0000);
    check("R1 no extra commands", 16'(exp_q.size()), 16'd0);

    // R5: end-of-discharge save, two passes
    exp_block(1'b0, 16'h2222, 16'h4444, 0);
    exp_block(1'b1, 16'h2222, 16'h4444, 0);
    send(2'd2, 16'h2222, 16'h4444);
    wait_idle();
    check("R5 pair1 A", mem[3][0], 16'h2222);
    check("R5 pair1 B", mem[4][0], 16'h4444);
    check("R5 all commands seen", 16'(exp_q.size()), 16'd0);

    // R6: power loss during destination erase, restore replays
    exp_block(1'b0, 16'h5555, 16'h6666, 0);
    send(2'd0, 16'h5555, 16'h6666);
    for (int i = 0; i < 2000 && mem[0][2] !== mark(1'b0); i++) @(negedge clk);
    repeat (6) @(negedge clk);
    rst_n = 0;
    exp_q.delete();
    check("R6 marker present at loss", mem[0][2], mark(1'b0));
    push(2'd0, 3'd0, 2'd2, '0);
    push(2'd0, 3'd0, 2'd0, '0);
    push(2'd0, 3'd0, 2'd1, '0);
    exp_block(1'b0, 16'h5555, 16'h6666, 4);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    wait_idle();
    check("R6 restored A", mem[1][0], 16'h5555);
    check("R6 restored B", mem[2][0], 16'h6666);
    check("R6 marker cleared", mem[0][2], 16'h0000);
    check("R6 all commands seen", 16'(exp_q.size()), 16'd0);

    // R7: cleared marker at reset -> one read only
    rst_n = 0;
    push(2'd0, 3'd0, 2'd2, '0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    wait_idle();
    repeat (4) @(negedge clk);
    check("R7 single read then idle", {15'd0, busy}, 16'd0);
    check("R7 no replay", 16'(exp_q.size()), 16'd0);

    // R8: erase never completes
    hang = 1;
    push(2'd1, 3'd0, 2'd0, '0);
    send(2'd0, 16'h7777, 16'h8888);
    wait_idle();
    @(negedge clk);
    check("R8 err raised", {15'd0, err}, 16'd1);
    check("R8 busy dropped", {15'd0, busy}, 16'd0);
    check("R8 command dropped", {15'd0, fl_valid}, 16'd0);
    hang = 0;
    push(2'd1, 3'd5, 2'd0, '0);
    push(2'd2, 3'd5, 2'd0, 16'h1111);
    push(2'd2, 3'd5, 2'd1, 16'h9999);
    send(2'd1, 16'h1111, 16'h9999);
    check("R8 err cleared on accept", {15'd0, err}, 16'd0);
    wait_idle();
    check("R8 recovery all commands seen", 16'(exp_q.size()), 16'd0);
    finish_up();
  end
endmodule